// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line. A tick input, running at sixteen times the bit rate, times the sampling. Each frame has a low start bit, eight data bits sent least significant bit first, and one or two high stop bits. The line passes through a two-flop synchronizer. A falling edge arms the start detector, and the start bit is accepted only if the line is still low at its centre. After that, each data bit and the checked stop bit are sampled at their centres.

A finished frame updates a small register file, which software reaches over a simple read/write bus. Address 0 holds the status and control register and address 1 holds the received byte. The status register has a receive-full flag, an overrun flag and a framing-error flag. Each of these flags is cleared only by writing 0 to it after a status read that returned 1 for it. While either error flag is set, the receiver ignores the line. The line is also ignored while the enable bit is 0.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset the status register (address 0) reads 0x00 and the data register (address 1) reads 0x00. Reception is disabled.
- R2: Status/control bit layout is: bit 0 receive-full, bit 1 overrun, bit 2 framing error, bit 6 two-stop mode, bit 7 receive enable. Bits 6 and 7 are written directly. Read data appears on `bus_rdata` one clock after `bus_rd`. Writes to address 1 have no effect.
- R3: A valid frame (start low at its centre, 8 data bits LSB first at bit centres, checked stop bit high) received while receive-full is 0 loads the byte into the data register and sets receive-full.
- R4: A low pulse shorter than half a bit is rejected: no flag changes and the data register is unchanged. A valid frame that follows is received normally.
- R5: A frame completing while receive-full is 1 sets overrun. The data register keeps the earlier byte and the new byte is lost.
- R6: A frame whose checked stop bit is 0 sets framing error and loads its byte into the data register. Receive-full is not changed.
- R7: In two-stop mode only the first stop bit is checked. A 0 in the second stop bit raises no error.
- R8: While overrun or framing error is 1, no frame is received: flags and data do not change.
- R9: A flag is cleared only by a write of 0 to its bit when the last status read returned 1 for that bit and no status write has happened since. Writing 1, or writing 0 without such a read, leaves it unchanged.
- R10: With receive enable 0, no frame is received. Clearing receive enable leaves both error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = status/control, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with its default sizes: eight data bits and sixteen ticks per bit. It drives a tick every fourth clock, so one bit lasts 64 clocks. At that rate a full frame takes well under a thousand cycles, and this brings every frame-level case within reach: overrun, framing error, two-stop mode, false starts, blocking and disabled reception. The bench also covers the read-then-write-0 clearing rule, including a write that must not clear because no armed read came before it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP1 = 3'd3,
    RX_STOP2 = 3'd4
  } rx_state_t;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_FER  = 2;
  localparam int unsigned ST_TWO  = 6;
  localparam int unsigned ST_EN   = 7;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx,
  input  logic                 fall,
  input  logic                 allow,
  input  logic                 two_stop,
  output logic                 done,
  output logic                 done_ferr,
  output logic [DATA_BITS-1:0] done_byte,
  output logic                 idle
);
  localparam int unsigned CW   = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  rx_state_t            st;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 ferr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      ferr_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!allow) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          RX_IDLE: begin
            cnt  <= '0;
            bitn <= '0;
            if (fall) st <= RX_START;
          end
          RX_START: if (tick) begin
            if (cnt == HALF_LAST) begin
              cnt <= '0;
              st  <= rx ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            if (cnt == FULL_LAST) begin
              cnt   <= '0;
              shreg <= {rx, shreg[DATA_BITS-1:1]};
              if (bitn == BIT_LAST) st <= RX_STOP1;
              else bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP1: if (tick) begin
            if (cnt == FULL_LAST) begin
              cnt    <= '0;
              ferr_q <= ~rx;
              if (two_stop) begin
                st <= RX_STOP2;
              end else begin
                done <= 1'b1;
                st   <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP2: if (tick) begin
            if (cnt == FULL_LAST) begin
              cnt  <= '0;
              done <= 1'b1;
              st   <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_ferr = ferr_q;
  assign done_byte = shreg;
  assign idle      = (st == RX_IDLE);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic                 done_ferr,
  input  logic [DATA_BITS-1:0] done_byte,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 enable,
  output logic                 two_stop,
  output logic                 full,
  output logic                 ovr,
  output logic                 fer,
  output logic [DATA_BITS-1:0] data_q
);
  localparam int unsigned NFLAG = 3;

  logic [NFLAG-1:0] flags, arm, flags_nx;
  logic [7:0]       status;

  assign full = flags[ST_FULL];
  assign ovr  = flags[ST_OVR];
  assign fer  = flags[ST_FER];

  always_comb begin
    status         = '0;
    status[ST_FULL] = flags[ST_FULL];
    status[ST_OVR]  = flags[ST_OVR];
    status[ST_FER]  = flags[ST_FER];
    status[ST_TWO]  = two_stop;
    status[ST_EN]   = enable;
  end

  always_comb begin
    flags_nx = flags;
    if (bus_wr && !bus_addr) begin
      for (int i = 0; i < NFLAG; i++)
        if (arm[i] && !bus_wdata[i]) flags_nx[i] = 1'b0;
    end
    if (done) begin
      if (done_ferr)            flags_nx[ST_FER]  = 1'b1;
      else if (flags[ST_FULL])  flags_nx[ST_OVR]  = 1'b1;
      else                      flags_nx[ST_FULL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      arm       <= '0;
      enable    <= 1'b0;
      two_stop  <= 1'b0;
      data_q    <= '0;
      bus_rdata <= '0;
    end else begin
      flags <= flags_nx;
      if (done && (done_ferr || !flags[ST_FULL])) data_q <= done_byte;
      if (bus_wr && !bus_addr) begin
        arm      <= '0;
        enable   <= bus_wdata[ST_EN];
        two_stop <= bus_wdata[ST_TWO];
      end else if (bus_rd && !bus_addr) begin
        arm <= flags;
      end
      if (bus_rd) bus_rdata <= bus_addr ? 8'(data_q) : status;
    end
  end
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned OSR       = 16,
  parameter int unsigned SYNC_FF   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_line,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  logic                 rx_s, rx_fall;
  logic                 done, done_ferr, fr_idle;
  logic [DATA_BITS-1:0] done_byte, data_q;
  logic                 enable, two_stop, full, ovr, fer;
  logic                 allow;

  assign allow = enable & ~ovr & ~fer;

  uart_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(rx_s), .fall(rx_fall)
  );

  uart_rx_framer #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_framer (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx_s), .fall(rx_fall),
    .allow(allow), .two_stop(two_stop), .done(done),
    .done_ferr(done_ferr), .done_byte(done_byte), .idle(fr_idle)
  );

  uart_rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
    .clk(clk), .rst(rst), .done(done), .done_ferr(done_ferr),
    .done_byte(done_byte), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enable(enable), .two_stop(two_stop), .full(full), .ovr(ovr),
    .fer(fer), .data_q(data_q)
  );
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 full,
  input logic                 ovr,
  input logic                 fer,
  input logic                 done,
  input logic                 fr_idle,
  input logic                 bus_wr,
  input logic                 bus_addr,
  input logic [7:0]           bus_wdata,
  input logic [DATA_BITS-1:0] data_q
);
  a_r9_full_clears_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(full) |-> $past(bus_wr && !bus_addr && !bus_wdata[0]));

  a_r9_ovr_clears_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr) |-> $past(bus_wr && !bus_addr && !bus_wdata[1]));

  a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $stable(data_q));

  a_r6_fer_not_full: assert property (@(posedge clk) disable iff (rst)
    $rose(fer) |-> !$rose(full));

  a_r8_blocked_stays_idle: assert property (@(posedge clk) disable iff (rst)
    ((ovr || fer) && fr_idle) |=> fr_idle);

  a_r3_flag_rise_needs_frame: assert property (@(posedge clk) disable iff (rst)
    ($rose(full) || $rose(ovr) || $rose(fer)) |-> $past(done));
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .full(full), .ovr(ovr), .fer(fer), .done(done),
  .fr_idle(fr_idle), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .data_q(data_q)
);

// File: tb/uart_rx_sticky_bench.sv
module uart_rx_sticky_bench;
  localparam int TD  = 4;
  localparam int BIT = 16 * TD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int         total = 0, bad = 0, tdiv = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TD-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TD-1);
  end

  uart_rx_sticky u_uart_rx_sticky (
    .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // reference model state
  logic       m_full = 0, m_ovr = 0, m_fer = 0, m_en = 0, m_two = 0;
  logic [2:0] m_arm = '0;
  logic [7:0] m_data = '0;

  typedef struct packed { logic [7:0] st; logic [7:0] dat; } exp_t;
  exp_t q[$];

  function automatic logic [7:0] m_status();
    return {m_en, m_two, 3'b000, m_fer, m_ovr, m_full};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
    if (!a) m_arm = {m_fer, m_ovr, m_full};
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
    if (!a) begin
      if (m_arm[0] && !v[0]) m_full = 0;
      if (m_arm[1] && !v[1]) m_ovr  = 0;
      if (m_arm[2] && !v[2]) m_fer  = 0;
      m_arm = '0;
      m_en  = v[7];
      m_two = v[6];
    end
  endtask

  // driver: sends one frame, pushes expected register contents
  task automatic send(logic [7:0] b, logic s1, logic s2);
    if (m_en && !m_ovr && !m_fer) begin
      if (!s1) begin m_fer = 1; m_data = b; end
      else if (m_full) m_ovr = 1;
      else begin m_full = 1; m_data = b; end
    end
    @(negedge clk); rx_line = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx_line = s1; repeat (BIT) @(negedge clk);
    rx_line = s2; repeat (BIT) @(negedge clk);
    rx_line = 1;  repeat (BIT) @(negedge clk);
    q.push_back('{st: m_status(), dat: m_data});
  endtask

  // monitor: pops expected item and compares against the registers
  task automatic monitor(string tag);
    exp_t e;
    logic [7:0] s, d;
    e = q.pop_front();
    bus_read(1'b0, s);
    bus_read(1'b1, d);
    check({tag, " status"}, s, e.st);
    check({tag, " data"}, d, e.dat);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    bus_read(1'b0, v); check("R1 reset status", v, 8'h00);
    bus_read(1'b1, v); check("R1 reset data", v, 8'h00);

    // R10: disabled receiver ignores frames
    send(8'h77, 1, 1); monitor("R10 disabled");

    bus_write(1'b0, 8'h80);
    bus_read(1'b0, v); check("R2 enable bit", v, 8'h80);
    bus_write(1'b1, 8'hEE);
    bus_read(1'b1, v); check("R2 data write ignored", v, 8'h00);

    send(8'hA5, 1, 1); monitor("R3 good frame");
    send(8'h3C, 1, 1); monitor("R5 overrun");
    send(8'h11, 1, 1); monitor("R8 blocked by overrun");

    // R9: write 1s disarms, then write 0 without read must not clear
    bus_read(1'b0, v);
    bus_write(1'b0, 8'h87);
    bus_write(1'b0, 8'h80);
    bus_read(1'b0, v); check("R9 no clear without read", v, m_status());
    bus_write(1'b0, 8'h80);
    bus_read(1'b0, v); check("R9 clear after read", v, 8'h80);

    // R4: short glitch rejected
    @(negedge clk); rx_line = 0;
    repeat (3*TD) @(negedge clk); rx_line = 1;
    repeat (2*BIT) @(negedge clk);
    q.push_back('{st: m_status(), dat: m_data}); monitor("R4 glitch");
    send(8'h81, 1, 1); monitor("R4 frame after glitch");
    bus_read(1'b0, v); bus_write(1'b0, 8'h80);

    send(8'h5A, 0, 1); monitor("R6 framing error");
    send(8'h22, 1, 1); monitor("R8 blocked by framing error");

    // R10: clearing enable keeps error flags
    bus_write(1'b0, 8'h04);
    bus_read(1'b0, v); check("R10 fer kept when disabled", v, 8'h04);
    bus_write(1'b0, 8'hC0);
    bus_read(1'b0, v); check("R9 fer cleared", v, 8'hC0);

    send(8'hC3, 1, 0); monitor("R7 second stop ignored");
    bus_read(1'b0, v); bus_write(1'b0, 8'hC0);
    send(8'h3E, 0, 1); monitor("R7 first stop checked");
    bus_read(1'b0, v); bus_write(1'b0, 8'h80);
    send(8'h01, 1, 1); monitor("R3 one-stop after clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule